// File: doc/BRIEF.md
# Binary64 to Binary32 Round-to-Odd Narrowing Converter

This block narrows one double-precision operand to single precision with round-to-odd rounding. Any rounding mode chosen elsewhere has no effect on it. The conversion first truncates toward zero. When that truncation loses any bit, the least-significant bit of the 32-bit encoding is forced to 1. A later narrowing step that rounds this intermediate result then gets the same answer as a single direct rounding, so no double-rounding error appears. The block handles normal numbers, results that fall into the subnormal range, zeros, infinities, NaNs and overflow.

The source side is a valid/ready handshake that carries the 64-bit operand together with the caller's sticky exception-flag word. Every accepted operand produces a registered result one clock later. That result comes with the incoming flag word, ORed with the flags this conversion raised. The block accepts a new operand on every cycle, so it streams at full rate.

Top module: `f64_to_f32_rto`

## Requirements
- R1: While `rst` is high, `in_ready` is low. `in_ready` is high on every cycle after reset. An operand accepted on one clock edge raises `out_valid` after that edge, and `out_valid` is low after any edge at which no operand was accepted.
- R2: After a reset edge, `out_valid`, `out_data` and `out_flags` are all zero.
- R3: A source biased exponent from 897 to 1150 gives a normal result with the same sign, the exponent reduced by 896, and the top 23 source fraction bits, truncated toward zero. If any of the 29 dropped fraction bits is 1, bit 0 of the result is set to 1 and inexact is raised.
- R4: A source biased exponent of 1151 or more (but not 2047) gives the signed largest finite value: exponent field 0xFE and fraction all ones (0x7F7FFFFF with the sign in bit 31). Overflow and inexact are both raised.
- R5: A source biased exponent from 1 to 896 gives the truncated subnormal or zero, with exponent field 0. If any bit is lost, bit 0 is forced to 1 and both underflow and inexact are raised. An exact result raises no flag.
- R6: A source subnormal (exponent 0, nonzero fraction) gives the signed smallest subnormal, 0x00000001, and raises underflow and inexact.
- R7: A NaN source gives a NaN with the same sign, exponent field 0xFF, bit 22 set, and bits 21:0 taken from source bits 50:29. Invalid is raised only when source bit 51 is 0 (a signalling NaN).
- R8: Signed zeros and signed infinities map to the same-signed zero (0x00000000) and infinity (0x7F800000). No flag is raised.
- R9: The flag word has invalid in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0. `out_flags` equals the `flags_in` value that was accepted with the operand, ORed with the new flags. A set input bit is never cleared.
- R10: Operands presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_data | input | 64 | Binary64 operand |
| flags_in | input | 4 | Sticky flags accepted with the operand |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Binary32 result |
| out_flags | output | 4 | Sticky flags with this conversion's flags merged |

## Verification
Two events can land on the same output word in one cycle: the forced odd bit and an underflow or overflow. Three cases provoke this. The first is tiny operands whose truncation is already even (for example 2^-127 plus one source ulp). The second is operands below half the smallest subnormal, where truncation gives zero. The third is operands just past the top of the range, where the saturated value is already odd. In each case, the data word and all four flag bits are compared against values worked out by hand. In the same way, the sticky merge and the raising of a new flag are made to coincide by presenting inexact or signalling-NaN operands with some input flags already set. The result must show the union of the input flags and the new flags.

// File: rtl/rto_pkg.sv
package rto_pkg;

  // Default source and destination formats.
  localparam int F64_EXP_W  = 11;
  localparam int F64_FRAC_W = 52;
  localparam int F32_EXP_W  = 8;
  localparam int F32_FRAC_W = 23;

  // Exception flags, MSB first: invalid, overflow, underflow, inexact.
  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } exc_flags_t;

  // Operand categories as seen by the narrowing datapath.
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_TINY_SRC,
    CLS_NORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } opclass_t;

endpackage

// File: rtl/rto_classify.sv
module rto_classify
  import rto_pkg::*;
#(
  parameter int EXP_W  = F64_EXP_W,
  parameter int FRAC_W = F64_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] operand,
  output opclass_t          cls,
  output logic              sign,
  output logic [EXP_W-1:0]  exp,
  output logic [FRAC_W-1:0] frac
);

  assign sign = operand[WORD_W-1];
  assign exp  = operand[WORD_W-2 -: EXP_W];
  assign frac = operand[FRAC_W-1:0];

  always_comb begin
    if (exp == '0) begin
      cls = (frac == '0) ? CLS_ZERO : CLS_TINY_SRC;
    end else if (&exp) begin
      if (frac == '0)           cls = CLS_INF;
      else if (frac[FRAC_W-1])  cls = CLS_QNAN;
      else                      cls = CLS_SNAN;
    end else begin
      cls = CLS_NORMAL;
    end
  end

endmodule

// File: rtl/rto_sticky_shift.sv
module rto_sticky_shift #(
  parameter int W    = 23,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout,
  output logic            lost
);

  logic [W-1:0] stage [SH_W+1];
  logic [SH_W:0] stk;

  assign stage[0] = din;
  assign stk[0]   = 1'b0;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    if (STEP >= W) begin : g_flush
      assign stage[g+1] = amt[g] ? '0 : stage[g];
      assign stk[g+1]   = stk[g] | (amt[g] & (|stage[g]));
    end else begin : g_shift
      assign stage[g+1] = amt[g] ? (stage[g] >> STEP) : stage[g];
      assign stk[g+1]   = stk[g] | (amt[g] & (|stage[g][STEP-1:0]));
    end
  end

  assign dout = stage[SH_W];
  assign lost = stk[SH_W];

endmodule

// File: rtl/rto_narrow.sv
module rto_narrow
  import rto_pkg::*;
#(
  parameter int SRC_EXP_W  = F64_EXP_W,
  parameter int SRC_FRAC_W = F64_FRAC_W,
  parameter int DST_EXP_W  = F32_EXP_W,
  parameter int DST_FRAC_W = F32_FRAC_W,
  localparam int DST_W = 1 + DST_EXP_W + DST_FRAC_W
) (
  input  opclass_t              cls,
  input  logic                  sign,
  input  logic [SRC_EXP_W-1:0]  exp,
  input  logic [SRC_FRAC_W-1:0] frac,
  output logic [DST_W-1:0]      result,
  output exc_flags_t            flags
);

  localparam int SRC_BIAS    = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS    = (1 << (DST_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF   = SRC_BIAS - DST_BIAS;
  localparam int DST_EXP_TOP = (1 << DST_EXP_W) - 1;
  localparam int FRAC_DROP   = SRC_FRAC_W - DST_FRAC_W;
  localparam int SH_W        = $clog2(DST_FRAC_W + 1);
  localparam int SH_SAT      = (1 << SH_W) - 1;

  localparam logic [SRC_EXP_W-1:0] EXP_OVF      = SRC_EXP_W'(BIAS_DIFF + DST_EXP_TOP);
  localparam logic [SRC_EXP_W-1:0] EXP_MIN_NORM = SRC_EXP_W'(BIAS_DIFF + 1);
  localparam logic [SRC_EXP_W-1:0] EXP_SUB_BASE = SRC_EXP_W'(BIAS_DIFF);
  localparam logic [SRC_EXP_W-1:0] SH_SAT_E     = SRC_EXP_W'(SH_SAT);
  localparam logic [DST_EXP_W-1:0] EXP_MAXFIN   = DST_EXP_W'(DST_EXP_TOP - 1);

  // Normal-range path: rebias and truncate.
  logic [DST_EXP_W-1:0]  norm_exp;
  logic [DST_FRAC_W-1:0] norm_frac;
  logic                  norm_lost;

  assign norm_exp  = DST_EXP_W'(exp - EXP_SUB_BASE);
  assign norm_frac = frac[SRC_FRAC_W-1 -: DST_FRAC_W];
  assign norm_lost = |frac[FRAC_DROP-1:0];

  // Tiny path: a fixed drop of FRAC_DROP+1 bits, then a variable shift.
  logic [SRC_EXP_W-1:0]  sub_dist;
  logic [SH_W-1:0]       sub_sh;
  logic [DST_FRAC_W-1:0] sub_sig;
  logic [DST_FRAC_W-1:0] sub_frac;
  logic                  sub_fixed_lost;
  logic                  sub_shift_lost;
  logic                  sub_lost;

  assign sub_dist       = EXP_SUB_BASE - exp;
  assign sub_sh         = (sub_dist > SH_SAT_E) ? SH_W'(SH_SAT) : sub_dist[SH_W-1:0];
  assign sub_sig        = {1'b1, frac[SRC_FRAC_W-1 -: DST_FRAC_W-1]};
  assign sub_fixed_lost = |frac[FRAC_DROP:0];
  assign sub_lost       = sub_fixed_lost | sub_shift_lost;

  rto_sticky_shift #(
    .W    (DST_FRAC_W),
    .SH_W (SH_W)
  ) u_shift (
    .din  (sub_sig),
    .amt  (sub_sh),
    .dout (sub_frac),
    .lost (sub_shift_lost)
  );

  always_comb begin
    result = '0;
    flags  = '0;
    unique case (cls)
      CLS_ZERO: begin
        result = {sign, {(DST_W-1){1'b0}}};
      end
      CLS_INF: begin
        result = {sign, {DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
      end
      CLS_QNAN, CLS_SNAN: begin
        result        = {sign, {DST_EXP_W{1'b1}}, 1'b1, frac[SRC_FRAC_W-2 -: DST_FRAC_W-1]};
        flags.invalid = (cls == CLS_SNAN);
      end
      CLS_TINY_SRC: begin
        result          = {sign, {(DST_W-1){1'b0}}};
        flags.underflow = 1'b1;
        flags.inexact   = 1'b1;
      end
      default: begin
        if (exp >= EXP_OVF) begin
          result         = {sign, EXP_MAXFIN, {DST_FRAC_W{1'b1}}};
          flags.overflow = 1'b1;
          flags.inexact  = 1'b1;
        end else if (exp >= EXP_MIN_NORM) begin
          result        = {sign, norm_exp, norm_frac};
          flags.inexact = norm_lost;
        end else begin
          result          = {sign, {DST_EXP_W{1'b0}}, sub_frac};
          flags.inexact   = sub_lost;
          flags.underflow = sub_lost;
        end
      end
    endcase
    // Round to odd: any lost precision makes the encoding odd.
    if (flags.inexact) result[0] = 1'b1;
  end

endmodule

// File: rtl/f64_to_f32_rto.sv
module f64_to_f32_rto
  import rto_pkg::*;
#(
  parameter int SRC_EXP_W  = F64_EXP_W,
  parameter int SRC_FRAC_W = F64_FRAC_W,
  parameter int DST_EXP_W  = F32_EXP_W,
  parameter int DST_FRAC_W = F32_FRAC_W,
  localparam int SRC_W  = 1 + SRC_EXP_W + SRC_FRAC_W,
  localparam int DST_W  = 1 + DST_EXP_W + DST_FRAC_W,
  localparam int FLAG_W = $bits(exc_flags_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_data,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [DST_W-1:0]  out_data,
  output logic [FLAG_W-1:0] out_flags
);

  localparam logic [DST_W-2:0] MAG_MAXFIN =
    {DST_EXP_W'((1 << DST_EXP_W) - 2), {DST_FRAC_W{1'b1}}};

  opclass_t               cls;
  logic                   src_sign;
  logic [SRC_EXP_W-1:0]   src_exp;
  logic [SRC_FRAC_W-1:0]  src_frac;
  logic [DST_W-1:0]       n_result;
  exc_flags_t             n_flags;
  logic                   ready_q;
  logic                   accept;

  rto_classify #(
    .EXP_W  (SRC_EXP_W),
    .FRAC_W (SRC_FRAC_W)
  ) u_classify (
    .operand (in_data),
    .cls     (cls),
    .sign    (src_sign),
    .exp     (src_exp),
    .frac    (src_frac)
  );

  rto_narrow #(
    .SRC_EXP_W  (SRC_EXP_W),
    .SRC_FRAC_W (SRC_FRAC_W),
    .DST_EXP_W  (DST_EXP_W),
    .DST_FRAC_W (DST_FRAC_W)
  ) u_narrow (
    .cls    (cls),
    .sign   (src_sign),
    .exp    (src_exp),
    .frac   (src_frac),
    .result (n_result),
    .flags  (n_flags)
  );

  assign in_ready = ready_q;
  assign accept   = in_valid & ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= accept;
      if (accept) begin
        out_data  <= n_result;
        out_flags <= flags_in | FLAG_W'(n_flags);
      end
    end
  end

  // R1: one result per accepted operand, exactly one cycle later.
  a_r1_valid_follows_accept: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && in_ready));

  // R1: ready comes up after reset and stays up.
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);

  // R9: incoming sticky bits survive.
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_flags & $past(flags_in)) == $past(flags_in)));

  // R3: an even result means no new inexact flag.
  a_r3_even_means_exact: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_data[0]) |-> (out_flags[0] == $past(flags_in[0])));

  // R4: a newly raised overflow comes with the largest finite magnitude.
  a_r4_overflow_saturates: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flags[2] && !$past(flags_in[2]))
      |-> (out_data[DST_W-2:0] == MAG_MAXFIN && out_flags[0]));

  // R5: a newly raised underflow comes with inexact and a zero exponent field.
  a_r5_underflow_tiny: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_flags[1] && !$past(flags_in[1]))
      |-> (out_flags[0] && out_data[DST_W-2 -: DST_EXP_W] == '0));

  // R7: every NaN leaving the block is quiet.
  a_r7_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (&out_data[DST_W-2 -: DST_EXP_W]) && (|out_data[DST_FRAC_W-1:0]))
      |-> out_data[DST_FRAC_W-1]);

endmodule

// File: tb/f64_to_f32_rto_tb.sv
module f64_to_f32_rto_tb;

  localparam logic [3:0] NONE = 4'b0000;
  localparam logic [3:0] NX   = 4'b0001;
  localparam logic [3:0] UF   = 4'b0010;
  localparam logic [3:0] OF   = 4'b0100;
  localparam logic [3:0] NV   = 4'b1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  flags_in = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  f64_to_f32_rto u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_flags (out_flags)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic chk_result(input string req, input logic [31:0] ed, input logic [3:0] ef);
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "out_data",  64'(out_data),  64'(ed));
    chk(req, "out_flags", 64'(out_flags), 64'(ef));
  endtask

  // Present one operand at a falling edge; check the result at the next one.
  task automatic conv(input string req, input logic [63:0] op, input logic [3:0] fin,
                      input logic [31:0] ed, input logic [3:0] ef);
    in_valid = 1'b1;
    in_data  = op;
    flags_in = fin;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    flags_in = '0;
    chk_result(req, ed, ef);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R2", "out_data in reset",  64'(out_data),  64'd0);
    chk("R2", "out_flags in reset", 64'(out_flags), 64'd0);
    chk("R1", "in_ready in reset",  64'(in_ready),  64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready after reset", 64'(in_ready),  64'd1);
    chk("R1", "idle out_valid",       64'(out_valid), 64'd0);
  endtask

  task automatic test_normal();  // R3
    conv("R3", 64'h3FF0000000000000, NONE, 32'h3F800000, NONE);
    conv("R3", 64'h3FF0000000000001, NONE, 32'h3F800001, NX);
    conv("R3", 64'h3FF0000020000001, NONE, 32'h3F800001, NX);
    conv("R3", 64'hC00921FB54442D18, NONE, 32'hC0490FDB, NX);
    conv("R3", 64'h3FFFFFFFFFFFFFFF, NONE, 32'h3FFFFFFF, NX);
    conv("R3", 64'h3FF8000000001000, NONE, 32'h3FC00001, NX);
    conv("R3", 64'h47EFFFFFE0000000, NONE, 32'h7F7FFFFF, NONE);
    conv("R3", 64'h3810000000000000, NONE, 32'h00800000, NONE);
  endtask

  task automatic test_overflow();  // R4
    conv("R4", 64'h47F0000000000000, NONE, 32'h7F7FFFFF, OF | NX);
    conv("R4", 64'hC7F0000000000000, NONE, 32'hFF7FFFFF, OF | NX);
    conv("R4", 64'h7FEFFFFFFFFFFFFF, NONE, 32'h7F7FFFFF, OF | NX);
  endtask

  task automatic test_tiny();  // R5
    conv("R5", 64'h3800000000000000, NONE, 32'h00400000, NONE);
    conv("R5", 64'h36A0000000000000, NONE, 32'h00000001, NONE);
    conv("R5", 64'h3690000000000000, NONE, 32'h00000001, UF | NX);
    conv("R5", 64'h3800000000000001, NONE, 32'h00400001, UF | NX);
    conv("R5", 64'hB800000000000001, NONE, 32'h80400001, UF | NX);
    conv("R5", 64'h0010000000000000, NONE, 32'h00000001, UF | NX);
  endtask

  task automatic test_src_subnormal();  // R6
    conv("R6", 64'h0000000000000001, NONE, 32'h00000001, UF | NX);
    conv("R6", 64'h8000000000000001, NONE, 32'h80000001, UF | NX);
    conv("R6", 64'h000FFFFFFFFFFFFF, NONE, 32'h00000001, UF | NX);
  endtask

  task automatic test_nan();  // R7
    conv("R7", 64'h7FF8000000000000, NONE, 32'h7FC00000, NONE);
    conv("R7", 64'h7FF0000000000001, NONE, 32'h7FC00000, NV);
    conv("R7", 64'hFFF4000020000000, NONE, 32'hFFE00001, NV);
    conv("R7", 64'hFFFC000060000000, NONE, 32'hFFE00003, NONE);
  endtask

  task automatic test_special();  // R8
    conv("R8", 64'h0000000000000000, NONE, 32'h00000000, NONE);
    conv("R8", 64'h8000000000000000, NONE, 32'h80000000, NONE);
    conv("R8", 64'h7FF0000000000000, NONE, 32'h7F800000, NONE);
    conv("R8", 64'hFFF0000000000000, NONE, 32'hFF800000, NONE);
  endtask

  task automatic test_flag_merge();  // R9
    conv("R9", 64'h3FF0000000000001, NV,   32'h3F800001, NV | NX);
    conv("R9", 64'h3FF0000000000000, 4'hF, 32'h3F800000, 4'hF);
    conv("R9", 64'h7FF0000000000001, OF,   32'h7FC00000, NV | OF);
    conv("R9", 64'h3690000000000000, NX,   32'h00000001, UF | NX);
    conv("R9", 64'h0000000000000000, UF,   32'h00000000, UF);
  endtask

  task automatic test_stream();  // R10, R1
    in_valid = 1'b1;
    in_data  = 64'h4000000000000000;
    flags_in = NONE;
    @(negedge clk);
    chk_result("R10", 32'h40000000, NONE);
    in_data  = 64'h47F0000000000000;
    @(negedge clk);
    chk_result("R10", 32'h7F7FFFFF, OF | NX);
    in_data  = 64'h7FF0000000000001;
    @(negedge clk);
    chk_result("R10", 32'h7FC00000, NV);
    in_valid = 1'b0;
    in_data  = '0;
    @(negedge clk);
    chk("R1", "out_valid after stream", 64'(out_valid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    test_reset();
    test_normal();
    test_overflow();
    test_tiny();
    test_src_subnormal();
    test_nan();
    test_special();
    test_flag_merge();
    test_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule